// File: doc/BRIEF.md
# SRAM Check-Error Policy Unit

This unit sits between the SRAM regions of a microcontroller and the system's interrupt and reset logic. The parity-protected regions report parity failures as one-cycle strobes: three main banks, a high region and the cache RAM. The two ECC-protected regions, region A and region B, present a raw 32-bit word with 7 check bits on a shared read port. The unit runs a single-error-correct, double-error-detect decode on that word and returns the corrected data one cycle later.

Every failure is recorded in a sticky flag. Depending on a programmable ECC mode and a per-group action bit, a failure can also produce a one-cycle request for a non-maskable interrupt or for a system reset. The check-control register can only be written after an unlock key has been written to a separate key register.

Top module: `sram_check_policy`

## Requirements
- R1: After reset, `status_o` is 0, `ctrl_o` is 0, the key register is locked, and both `nmi_o` and `rst_req_o` are low.
- R2: Writes use `cfg_addr`: 0 is the key register, 1 is the check-control register, 2 is the flag register. Writing 0x77 to the key register unlocks the check-control register. Writing 0x76 locks it again. Any other key value leaves the lock state unchanged. A write to the check-control register while it is locked leaves `ctrl_o` unchanged.
- R3: Check-control fields are as follows. Bits [5:4] hold the ECC mode. Bits [3:0] hold the action bits, where 0 selects an NMI request and 1 selects a reset request. Bit 0 serves the three banks and the cache RAM, bit 1 serves region A, bit 2 serves the high region, and bit 3 serves region B.
- R4: Bit k of `par_err_i` marks a parity failure. Bits 0 to 2 are the banks, bit 3 is the high region and bit 4 is the cache. A failure sets flag 0, 1, 2, 3 or 8 respectively, and pulses the request chosen by its action bit. Both the flag and the pulse appear one cycle after the strobe.
- R5: In ECC mode 0, read data passes through unchanged and sets no flag or event, even when the check bits disagree.
- R6: In modes 1 to 3, a word with a single-bit error (odd overall parity and a syndrome no greater than 38) is returned corrected. Mode 1 sets no flag and no event. Mode 2 sets the single-bit flag (4 for region A, 6 for region B) with no event. Mode 3 sets the flag and pulses the region's event.
- R7: In modes 1 to 3, any other nonzero check mismatch is a double-bit error. The data is returned as read, uncorrected. The double-bit flag is set (5 for region A, 7 for region B) and the region's event pulses.
- R8: Flags are sticky and are cleared by writing 1 to their bit at address 2. A flag being set in the same cycle as its clear stays set.
- R9: Codeword layout: codeword positions 1 to 38 carry the Hamming code. Check bit i sits at position 2^i and is `rd_chk_i[i]`. Data bits 0 to 31 fill the remaining positions in ascending order. `rd_chk_i[6]` makes the parity of all 39 bits even.
- R10: `rd_vld_o` and `rd_data_o` follow `rd_vld_i` by one cycle. `rd_sel_i` = 0 selects region A and 1 selects region B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| par_err_i | input | 5 | Parity failure strobes |
| rd_vld_i | input | 1 | ECC read valid |
| rd_sel_i | input | 1 | ECC region select |
| rd_data_i | input | 32 | Raw read data |
| rd_chk_i | input | 7 | Stored check bits |
| rd_vld_o | output | 1 | Corrected data valid |
| rd_data_o | output | 32 | Corrected data |
| nmi_o | output | 1 | NMI request pulse |
| rst_req_o | output | 1 | Reset request pulse |
| ctrl_o | output | 6 | Check-control register value |
| status_o | output | 9 | Sticky error flags |

## Verification
The bench flips data bits, Hamming check bits and the overall parity bit. A decoder that mishandles the overall parity bit would flag a double error where a harmless single error occurred. A decoder that corrects double errors would hand back silently wrong data. Mode changes are interleaved with injected single errors, so a design that flags or escalates in the wrong mode shows up as a stray flag or pulse. The bench also clears a flag in the same cycle a new error sets it, which catches a design where the clear wins. Writes with a wrong key and writes after re-locking catch a design whose key protection leaks.

// File: rtl/sram_check_policy.sv
module sram_check_policy #(
  parameter int DW = 32,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic [4:0]    par_err_i,
  input  logic          rd_vld_i,
  input  logic          rd_sel_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic [CW-1:0] rd_chk_i,
  output logic          rd_vld_o,
  output logic [DW-1:0] rd_data_o,
  output logic          nmi_o,
  output logic          rst_req_o,
  output logic [5:0]    ctrl_o,
  output logic [8:0]    status_o
);
  localparam int NPOS = DW + CW - 1;
  localparam int SW   = CW - 1;

  function automatic logic [SW-1:0] hsyn(input logic [DW-1:0] d);
    logic [SW-1:0] acc;
    int k;
    acc = '0;
    k = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < SW; i++)
          if (p[i]) acc[i] = acc[i] ^ d[k];
        k++;
      end
    end
    return acc;
  endfunction

  function automatic logic [DW-1:0] hfix(input logic [DW-1:0] d, input logic [SW-1:0] s);
    logic [DW-1:0] r;
    int k;
    r = d;
    k = 0;
    for (int p = 1; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p == int'(s)) r[k] = ~r[k];
        k++;
      end
    end
    return r;
  endfunction

  logic          unlocked;
  logic [5:0]    ctrl;
  logic [8:0]    status;

  wire [1:0]    mode   = ctrl[5:4];
  wire [SW-1:0] syn    = hsyn(rd_data_i) ^ rd_chk_i[SW-1:0];
  wire          odd    = ^{rd_data_i, rd_chk_i};
  wire          ecc_on = rd_vld_i && (mode != 2'd0);
  wire          sgl    = ecc_on && odd && (int'(syn) <= NPOS);
  wire          dbl    = ecc_on && !sgl && (odd || (syn != '0));
  wire          sflag  = sgl && (mode >= 2'd2);
  wire          ecc_ev = dbl || (sgl && (mode == 2'd3));
  wire          act_e  = rd_sel_i ? ctrl[3] : ctrl[1];
  wire          grp_b  = |{par_err_i[4], par_err_i[2:0]};
  wire          grp_h  = par_err_i[3];

  wire [8:0] set_v = {par_err_i[4],
                      rd_sel_i & dbl, rd_sel_i & sflag,
                      ~rd_sel_i & dbl, ~rd_sel_i & sflag,
                      par_err_i[3:0]};
  wire [8:0] clr_v = (cfg_we && cfg_addr == 2'd2) ? cfg_wdata[8:0] : 9'd0;

  wire nmi_d = (grp_b & ~ctrl[0]) | (grp_h & ~ctrl[2]) | (ecc_ev & ~act_e);
  wire rst_d = (grp_b &  ctrl[0]) | (grp_h &  ctrl[2]) | (ecc_ev &  act_e);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      ctrl      <= '0;
      status    <= '0;
      nmi_o     <= 1'b0;
      rst_req_o <= 1'b0;
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      nmi_o     <= nmi_d;
      rst_req_o <= rst_d;
      rd_vld_o  <= rd_vld_i;
      if (rd_vld_i) rd_data_o <= sgl ? hfix(rd_data_i, syn) : rd_data_i;
      status <= (status & ~clr_v) | set_v;
      if (cfg_we && cfg_addr == 2'd0) begin
        if (cfg_wdata == 32'h77)      unlocked <= 1'b1;
        else if (cfg_wdata == 32'h76) unlocked <= 1'b0;
      end
      if (cfg_we && cfg_addr == 2'd1 && unlocked) ctrl <= cfg_wdata[5:0];
    end
  end

  assign ctrl_o   = ctrl;
  assign status_o = status;
endmodule

// File: rtl/sram_check_policy_chk.sv
module sram_check_policy_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic [4:0]    par_err_i,
  input logic          rd_vld_i,
  input logic [DW-1:0] rd_data_i,
  input logic          rd_vld_o,
  input logic [DW-1:0] rd_data_o,
  input logic          nmi_o,
  input logic          rst_req_o,
  input logic [5:0]    ctrl_o,
  input logic [8:0]    status_o,
  input logic          unlocked
);
  a_r2_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd1 && !unlocked) |=> $stable(ctrl_o));

  a_r4_event_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o || rst_req_o) |-> $past(par_err_i != 5'd0 || rd_vld_i));

  a_r5_mode0_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld_i && ctrl_o[5:4] == 2'd0 && par_err_i == 5'd0)
      |=> (rd_data_o == $past(rd_data_i) && !nmi_o && !rst_req_o));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == 2'd2) |=> ((status_o & $past(status_o)) == $past(status_o)));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_i |=> rd_vld_o);
endmodule

bind sram_check_policy sram_check_policy_chk #(.DW(DW)) u_chk (.*);

// File: tb/sram_check_policy_test.sv
module sram_check_policy_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [4:0]  par_err_i = 0;
  logic        rd_vld_i = 0;
  logic        rd_sel_i = 0;
  logic [31:0] rd_data_i = 0;
  logic [6:0]  rd_chk_i = 0;
  logic        rd_vld_o;
  logic [31:0] rd_data_o;
  logic        nmi_o, rst_req_o;
  logic [5:0]  ctrl_o;
  logic [8:0]  status_o;

  sram_check_policy uut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic        vld;
    logic [31:0] data;
    logic        nmi;
    logic        rst;
    logic [5:0]  ctrl;
    logic [8:0]  st;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic       m_unl = 0;
  logic [5:0] m_ctrl = 0;
  logic [8:0] m_st = 0;

  function automatic logic [39:1] enc(input logic [31:0] d);
    logic [39:1] cw;
    logic b;
    int k;
    cw = '0;
    k = 0;
    for (int p = 1; p <= 38; p++)
      if ((p & (p - 1)) != 0) begin cw[p] = d[k]; k++; end
    for (int i = 0; i < 6; i++) begin
      b = 0;
      for (int p = 1; p <= 38; p++)
        if (((p >> i) & 1) == 1 && (p & (p - 1)) != 0) b = b ^ cw[p];
      cw[1 << i] = b;
    end
    cw[39] = ^cw[38:1];
    return cw;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [1:0] a, input logic [31:0] wd,
                      input logic [4:0] par, input logic vld, input logic sel,
                      input logic [31:0] orig, input int fa, input int fb,
                      input string req);
    logic [39:1] cw;
    logic [31:0] dat;
    logic [6:0]  ck;
    logic [1:0]  md;
    logic        ev, act_e, sflg, dflg;
    logic [8:0]  setv;
    int nfl, k;
    item_t it;
    @(negedge clk);
    cw = enc(orig);
    if (fa != 0) cw[fa] = ~cw[fa];
    if (fb != 0) cw[fb] = ~cw[fb];
    nfl = (fa != 0 ? 1 : 0) + (fb != 0 ? 1 : 0);
    k = 0;
    for (int p = 1; p <= 38; p++)
      if ((p & (p - 1)) != 0) begin dat[k] = cw[p]; k++; end
    for (int i = 0; i < 6; i++) ck[i] = cw[1 << i];
    ck[6] = cw[39];
    cfg_we = we; cfg_addr = a; cfg_wdata = wd; par_err_i = par;
    rd_vld_i = vld; rd_sel_i = sel; rd_data_i = dat; rd_chk_i = ck;

    md = m_ctrl[5:4];
    act_e = sel ? m_ctrl[3] : m_ctrl[1];
    it.vld = vld;
    it.data = dat;
    sflg = 0; dflg = 0; ev = 0;
    if (vld && md != 0) begin
      if (nfl == 1) begin
        it.data = orig;
        sflg = (md >= 2);
        ev = (md == 3);
      end else if (nfl == 2) begin
        dflg = 1;
        ev = 1;
      end
    end
    it.nmi = 0; it.rst = 0;
    if (par[0] | par[1] | par[2] | par[4]) begin
      if (m_ctrl[0]) it.rst = 1; else it.nmi = 1;
    end
    if (par[3]) begin
      if (m_ctrl[2]) it.rst = 1; else it.nmi = 1;
    end
    if (ev) begin
      if (act_e) it.rst = 1; else it.nmi = 1;
    end
    setv = 0;
    setv[3:0] = par[3:0];
    setv[8] = par[4];
    if (sel) begin setv[6] = sflg; setv[7] = dflg; end
    else     begin setv[4] = sflg; setv[5] = dflg; end
    if (we && a == 2) m_st = m_st & ~wd[8:0];
    m_st = m_st | setv;
    if (we && a == 1 && m_unl) m_ctrl = wd[5:0];
    if (we && a == 0) begin
      if (wd == 32'h77) m_unl = 1;
      else if (wd == 32'h76) m_unl = 0;
    end
    it.ctrl = m_ctrl;
    it.st = m_st;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string req);
    step(1, a, d, 0, 0, 0, 0, 0, 0, req);
  endtask

  task automatic rd(input logic sel, input logic [31:0] d, input int fa, input int fb,
                    input string req);
    step(0, 0, 0, 0, 1, sel, d, fa, fb, req);
  endtask

  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(rd_vld_o === it.vld, it.req, "rd_vld_o", 32'(rd_vld_o), 32'(it.vld));
        if (it.vld)
          chk(rd_data_o === it.data, it.req, "rd_data_o", rd_data_o, it.data);
        chk(nmi_o === it.nmi, it.req, "nmi_o", 32'(nmi_o), 32'(it.nmi));
        chk(rst_req_o === it.rst, it.req, "rst_req_o", 32'(rst_req_o), 32'(it.rst));
        chk(ctrl_o === it.ctrl, it.req, "ctrl_o", 32'(ctrl_o), 32'(it.ctrl));
        chk(status_o === it.st, it.req, "status_o", 32'(status_o), 32'(it.st));
      end
    end
  end

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(status_o === 9'd0, "R1", "status_o", 32'(status_o), 0);
    chk(ctrl_o === 6'd0, "R1", "ctrl_o", 32'(ctrl_o), 0);
    chk(nmi_o === 1'b0 && rst_req_o === 1'b0, "R1", "events",
        32'({nmi_o, rst_req_o}), 0);

    wr(1, 32'h3F, "R2 locked write");
    rd(0, 32'hDEADBEEF, 7, 0, "R5 mode0 raw");
    rd(1, 32'h12345678, 3, 12, "R5 mode0 double raw");
    wr(0, 32'h55, "R2 bad key");
    wr(1, 32'h3F, "R2 still locked");
    wr(0, 32'h77, "R2 unlock");
    wr(1, 32'h10, "R3 mode1");
    rd(0, 32'hCAFEF00D, 9, 0, "R6 mode1 silent");
    rd(1, 32'h0000FFFF, 38, 0, "R6 mode1 top bit");
    wr(1, 32'h20, "R3 mode2");
    rd(1, 32'hA5A5A5A5, 4, 0, "R6 mode2 chk bit");
    rd(0, 32'h00000001, 39, 0, "R9 overall bit");
    wr(1, 32'h32, "R3 mode3 A reset");
    rd(0, 32'h13579BDF, 21, 0, "R6 mode3 A reset");
    rd(1, 32'h2468ACE0, 5, 6, "R7 double B nmi");
    rd(0, 32'hFFFFFFFF, 39, 5, "R7 double A reset");
    rd(0, 32'h0F0F0F0F, 0, 0, "R9 clean");
    idle("R10 idle");
    step(0, 0, 0, 5'b00001, 0, 0, 0, 0, 0, "R4 bank parity nmi");
    wr(1, 32'h34, "R3 high reset");
    step(0, 0, 0, 5'b01000, 0, 0, 0, 0, 0, "R4 high parity reset");
    step(0, 0, 0, 5'b10000, 0, 0, 0, 0, 0, "R4 cache parity");
    step(0, 0, 0, 5'b00110, 1, 1, 32'h11111111, 16, 0, "R4 parity plus ecc");
    wr(2, 32'h009, "R8 clear");
    step(1, 2, 32'h010, 0, 1, 0, 32'h77777777, 11, 0, "R8 set wins");
    wr(2, 32'h1FF, "R8 clear all");
    wr(0, 32'h76, "R2 lock");
    wr(1, 32'h00, "R2 write after lock");
    rd(0, 32'h89ABCDEF, 2, 0, "R6 still mode3");
    idle("R10 idle");
    idle("R10 idle");

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule